// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides where the core goes when an exception is taken or when an exception-return instruction retires, and keeps the return addresses. There are three exception levels: general, error and debug. Each level has its own saved-PC register. When the faulting instruction sits in a branch delay slot, the saved PC is rewound by one instruction so that execution resumes at the branch. The block also keeps the branch-delay flag and the 5-bit exception code of the cause word, and it keeps the debug-mode flag.

The Status register lives outside the block. The block samples three of its bits: the exception level, the error level and the boot-vector select. It then returns single-cycle set and clear strobes for those bits and for the NMI and soft-reset flags. The fetch unit receives a new PC and a one-cycle redirect strobe, and the load-linked unit receives a clear pulse on every return. All outputs are registered, so every result appears on the cycle after the request is sampled.

Top module: `exc_seq`

## Requirements
- R1: `redirect_o` is high for exactly the one cycle after a cycle in which `exc_req_i`, `eret_i` or `deret_i` was high, and `npc_o` carries the new PC in that cycle. There is no redirect without a request.
- R2: For general-class exceptions (class 0 = general, class 1 = TLB refill), the vector base is 0x80000000 when `st_bev_i` is 0 and 0xBFC00200 when it is 1.
- R3: A TLB refill exception taken with `st_exl_i` = 0 adds offset 0x000 to the base. Every other general-class exception adds 0x180.
- R4: A general-class exception with `st_exl_i` = 0 writes PC to `epc_o`, or PC-4 when `in_dslot_i` is set. It copies `in_dslot_i` into the branch-delay bit (`cause_o` bit 31) and pulses `exl_set_o`.
- R5: A general-class exception with `st_exl_i` = 1 leaves `epc_o` and `cause_o` bit 31 unchanged and does not pulse `exl_set_o`.
- R6: Every general-class exception writes `exc_code_i` into `cause_o` bits 6:2. All other `cause_o` bits except bit 31 read 0.
- R7: An NMI (class 2) writes PC, or PC-4 in a delay slot, to `errorepc_o`. It pulses `erl_set_o`, `bev_set_o` and `nmi_set_o` and redirects to 0xBFC00000.
- R8: A soft reset (class 3) does the same as an NMI but pulses `sr_set_o` instead of `nmi_set_o`.
- R9: A debug exception (class 4) writes PC, or PC-4 in a delay slot, to `depc_o`. It sets `dbg_mode_o`, redirects to 0xBFC00480 and leaves `epc_o` unchanged.
- R10: ERET with `st_erl_i` = 1 redirects to `errorepc_o` and pulses `erl_clr_o`. With `st_erl_i` = 0 it redirects to `epc_o` and pulses `exl_clr_o`. Both cases pulse `ll_clr_o`.
- R11: DERET redirects to `depc_o`, clears `dbg_mode_o` and pulses `ll_clr_o`.
- R12: An exception request wins over a same-cycle ERET or DERET: no clear strobe and no `ll_clr_o`. ERET wins over DERET.
- R13: After reset, all saved PCs, `cause_o`, `dbg_mode_o`, `redirect_o` and every strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the faulting or returning instruction |
| in_dslot_i | input | 1 | Instruction is in a branch delay slot |
| exc_req_i | input | 1 | Exception request |
| exc_class_i | input | 3 | 0 general, 1 TLB refill, 2 NMI, 3 soft reset, 4 debug |
| exc_code_i | input | 5 | Exception code for general-class exceptions |
| eret_i | input | 1 | Exception return strobe |
| deret_i | input | 1 | Debug return strobe |
| st_exl_i | input | 1 | Status exception-level bit |
| st_erl_i | input | 1 | Status error-level bit |
| st_bev_i | input | 1 | Status boot-vector select bit |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| npc_o | output | XLEN | New PC |
| epc_o | output | XLEN | General exception return address |
| errorepc_o | output | XLEN | Error exception return address |
| depc_o | output | XLEN | Debug return address |
| cause_o | output | 32 | Bit 31 branch-delay flag, bits 6:2 exception code |
| dbg_mode_o | output | 1 | Debug mode (kernel privilege forced) |
| exl_set_o | output | 1 | Set Status exception level |
| exl_clr_o | output | 1 | Clear Status exception level |
| erl_set_o | output | 1 | Set Status error level |
| erl_clr_o | output | 1 | Clear Status error level |
| bev_set_o | output | 1 | Set Status boot-vector select |
| nmi_set_o | output | 1 | Set Status NMI flag |
| sr_set_o | output | 1 | Set Status soft-reset flag |
| ll_clr_o | output | 1 | Clear the load-linked flag |

## Verification
The bench targets the nested exception, where EXL is already set. A design that overwrote EPC there would lose the original return point, and a design that kept the refill offset would jump to the wrong handler. Delay-slot entries at every level check the PC-4 rewind; a missing rewind would resume one instruction past the branch. ERET is tested with ERL both set and clear, to catch a return through the wrong saved PC. An exception that collides with ERET must produce no load-linked clear and no level-clear strobe, because either would corrupt the state of the new handler.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      EXC_GEN    = 3'd0,
      EXC_REFILL = 3'd1,
      EXC_NMI    = 3'd2,
      EXC_SRST   = 3'd3,
      EXC_DBG    = 3'd4
   } exc_class_e;

   // offsets relative to the boot base / RAM base
   localparam logic [31:0] OFS_GEN_BOOT = 32'h0000_0200;
   localparam logic [31:0] OFS_OTHER    = 32'h0000_0180;
   localparam logic [31:0] OFS_DEBUG    = 32'h0000_0480;

   // saved-PC level indices
   localparam int unsigned LVL_GEN = 0;
   localparam int unsigned LVL_ERR = 1;
   localparam int unsigned LVL_DBG = 2;
   localparam int unsigned NLVL    = 3;

   localparam int unsigned CODE_W  = 5;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
   import exc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000,
   parameter logic [31:0] RAM_BASE  = 32'h8000_0000
) (
   input  exc_class_e       cls_i,
   input  logic             exl_i,
   input  logic             bev_i,
   output logic [XLEN-1:0]  vec_o
);

   localparam logic [XLEN-1:0] BOOT_X  = XLEN'($signed(BOOT_BASE));
   localparam logic [XLEN-1:0] RAM_X   = XLEN'($signed(RAM_BASE));
   localparam logic [XLEN-1:0] GBOOT_X = BOOT_X + XLEN'(OFS_GEN_BOOT);
   localparam logic [XLEN-1:0] DBG_X   = BOOT_X + XLEN'(OFS_DEBUG);
   localparam logic [XLEN-1:0] OTH_X   = XLEN'(OFS_OTHER);

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] ofs;

   always_comb begin
      base = bev_i ? GBOOT_X : RAM_X;
      ofs  = (cls_i == EXC_REFILL && !exl_i) ? '0 : OTH_X;
      unique case (cls_i)
         EXC_NMI, EXC_SRST: vec_o = BOOT_X;
         EXC_DBG:           vec_o = DBG_X;
         default:           vec_o = base + ofs;
      endcase
   end

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NLVL       = 3,
   parameter int unsigned INSN_BYTES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [XLEN-1:0]           pc_i,
   input  logic                      dslot_i,
   input  logic [NLVL-1:0]           we_i,
   output logic [NLVL-1:0][XLEN-1:0] save_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] resume_pc;
   assign resume_pc = dslot_i ? pc_i - STEP : pc_i;

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      always_ff @(posedge clk) begin
         if (!rst_n)
            save_o[g] <= '0;
         else if (we_i[g])
            save_o[g] <= resume_pc;
      end
   end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned INSN_BYTES = 4,
   parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0000,
   parameter logic [31:0] RAM_BASE   = 32'h8000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              in_dslot_i,
   input  logic              exc_req_i,
   input  logic [2:0]        exc_class_i,
   input  logic [4:0]        exc_code_i,
   input  logic              eret_i,
   input  logic              deret_i,
   input  logic              st_exl_i,
   input  logic              st_erl_i,
   input  logic              st_bev_i,
   output logic              redirect_o,
   output logic [XLEN-1:0]   npc_o,
   output logic [XLEN-1:0]   epc_o,
   output logic [XLEN-1:0]   errorepc_o,
   output logic [XLEN-1:0]   depc_o,
   output logic [31:0]       cause_o,
   output logic              dbg_mode_o,
   output logic              exl_set_o,
   output logic              exl_clr_o,
   output logic              erl_set_o,
   output logic              erl_clr_o,
   output logic              bev_set_o,
   output logic              nmi_set_o,
   output logic              sr_set_o,
   output logic              ll_clr_o
);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("exc_seq: XLEN must be 32 or 64");
   end
   if (INSN_BYTES == 0 || INSN_BYTES > 8) begin : g_bad_insn
      $error("exc_seq: INSN_BYTES out of range");
   end

   exc_class_e cls;
   assign cls = exc_class_e'(exc_class_i);

   logic take_gen, gen_first, take_err, take_dbg, do_eret, do_deret;
   always_comb begin
      take_err  = exc_req_i && (cls == EXC_NMI || cls == EXC_SRST);
      take_dbg  = exc_req_i && (cls == EXC_DBG);
      take_gen  = exc_req_i && !take_err && !take_dbg;
      gen_first = take_gen && !st_exl_i;
      do_eret   = eret_i && !exc_req_i;
      do_deret  = deret_i && !exc_req_i && !eret_i;
   end

   logic [XLEN-1:0] vec;
   exc_vec_sel #(
      .XLEN(XLEN), .BOOT_BASE(BOOT_BASE), .RAM_BASE(RAM_BASE)
   ) u_vec (
      .cls_i(cls), .exl_i(st_exl_i), .bev_i(st_bev_i), .vec_o(vec)
   );

   logic [NLVL-1:0]           save_we;
   logic [NLVL-1:0][XLEN-1:0] saved;
   assign save_we[LVL_GEN] = gen_first;
   assign save_we[LVL_ERR] = take_err;
   assign save_we[LVL_DBG] = take_dbg;

   exc_save_bank #(
      .XLEN(XLEN), .NLVL(NLVL), .INSN_BYTES(INSN_BYTES)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .dslot_i(in_dslot_i),
      .we_i(save_we), .save_o(saved)
   );

   assign epc_o      = saved[LVL_GEN];
   assign errorepc_o = saved[LVL_ERR];
   assign depc_o     = saved[LVL_DBG];

   logic              bd_q, dbg_q;
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_o <= 1'b0;
         npc_o      <= '0;
         exl_set_o  <= 1'b0;
         exl_clr_o  <= 1'b0;
         erl_set_o  <= 1'b0;
         erl_clr_o  <= 1'b0;
         bev_set_o  <= 1'b0;
         nmi_set_o  <= 1'b0;
         sr_set_o   <= 1'b0;
         ll_clr_o   <= 1'b0;
         bd_q       <= 1'b0;
         dbg_q      <= 1'b0;
         code_q     <= '0;
      end else begin
         redirect_o <= exc_req_i || eret_i || deret_i;
         if (exc_req_i)
            npc_o <= vec;
         else if (do_eret)
            npc_o <= st_erl_i ? saved[LVL_ERR] : saved[LVL_GEN];
         else if (do_deret)
            npc_o <= saved[LVL_DBG];
         exl_set_o <= gen_first;
         exl_clr_o <= do_eret && !st_erl_i;
         erl_set_o <= take_err;
         erl_clr_o <= do_eret && st_erl_i;
         bev_set_o <= take_err;
         nmi_set_o <= exc_req_i && cls == EXC_NMI;
         sr_set_o  <= exc_req_i && cls == EXC_SRST;
         ll_clr_o  <= do_eret || do_deret;
         if (take_gen)
            code_q <= exc_code_i;
         if (gen_first)
            bd_q <= in_dslot_i;
         if (take_dbg)
            dbg_q <= 1'b1;
         else if (do_deret)
            dbg_q <= 1'b0;
      end
   end

   assign dbg_mode_o = dbg_q;
   assign cause_o    = {bd_q, 24'd0, code_q, 2'b00};

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int unsigned XLEN      = 32,
   parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_req_i,
   input logic [2:0]      exc_class_i,
   input logic            eret_i,
   input logic            deret_i,
   input logic            st_exl_i,
   input logic            st_erl_i,
   input logic            redirect_o,
   input logic [XLEN-1:0] npc_o,
   input logic [XLEN-1:0] epc_o,
   input logic [XLEN-1:0] errorepc_o,
   input logic [XLEN-1:0] depc_o,
   input logic            dbg_mode_o,
   input logic            exl_set_o,
   input logic            erl_set_o,
   input logic            erl_clr_o,
   input logic            bev_set_o,
   input logic            nmi_set_o,
   input logic            exl_clr_o,
   input logic            ll_clr_o
);

   localparam logic [XLEN-1:0] BOOT_X = XLEN'($signed(BOOT_BASE));
   localparam logic [XLEN-1:0] DBG_X  = BOOT_X + XLEN'(32'h480);

   a_r1_request_redirects: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i || eret_i || deret_i) |=> redirect_o);

   a_r1_no_spurious_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_req_i || eret_i || deret_i) |=> !redirect_o);

   a_r5_nested_keeps_epc: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i && exc_class_i <= 3'd1 && st_exl_i) |=> (epc_o == $past(epc_o)) && !exl_set_o);

   a_r7_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i && exc_class_i == 3'd2) |=> erl_set_o && bev_set_o && nmi_set_o && npc_o == BOOT_X);

   a_r9_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i && exc_class_i == 3'd4) |=> dbg_mode_o && npc_o == DBG_X && epc_o == $past(epc_o));

   a_r10_eret_error_level: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && !exc_req_i && st_erl_i) |=> erl_clr_o && ll_clr_o && npc_o == $past(errorepc_o));

   a_r11_deret_leaves_debug: assert property (@(posedge clk) disable iff (!rst_n)
      (deret_i && !eret_i && !exc_req_i) |=> !dbg_mode_o && ll_clr_o && npc_o == $past(depc_o));

   a_r12_exception_wins: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req_i |=> !ll_clr_o && !exl_clr_o && !erl_clr_o);

endmodule

bind exc_seq exc_seq_chk #(.XLEN(XLEN), .BOOT_BASE(BOOT_BASE)) u_chk (.*);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic        in_dslot_i = 1'b0;
   logic        exc_req_i = 1'b0;
   logic [2:0]  exc_class_i = '0;
   logic [4:0]  exc_code_i = '0;
   logic        eret_i = 1'b0, deret_i = 1'b0;
   logic        st_exl_i = 1'b0, st_erl_i = 1'b0, st_bev_i = 1'b0;
   logic        redirect_o;
   logic [31:0] npc_o, epc_o, errorepc_o, depc_o, cause_o;
   logic        dbg_mode_o, exl_set_o, exl_clr_o, erl_set_o, erl_clr_o;
   logic        bev_set_o, nmi_set_o, sr_set_o, ll_clr_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   exc_seq dut (.*);

   typedef struct packed {
      logic [2:0]  cls;
      logic [4:0]  code;
      logic        bev;
      logic        exl;
      logic [31:0] npc;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      '{3'd0, 5'd4,  1'b0, 1'b0, 32'h8000_0180},   // R2 R3
      '{3'd1, 5'd2,  1'b0, 1'b0, 32'h8000_0000},   // R3 refill first level
      '{3'd1, 5'd3,  1'b0, 1'b1, 32'h8000_0180},   // R3 refill nested
      '{3'd1, 5'd2,  1'b1, 1'b0, 32'hBFC0_0200},   // R2 boot base
      '{3'd0, 5'd8,  1'b1, 1'b1, 32'hBFC0_0380},   // R2 R3
      '{3'd1, 5'd3,  1'b1, 1'b1, 32'hBFC0_0380},   // R3
      '{3'd2, 5'd0,  1'b0, 1'b0, 32'hBFC0_0000},   // R7
      '{3'd3, 5'd0,  1'b1, 1'b0, 32'hBFC0_0000},   // R8
      '{3'd4, 5'd0,  1'b0, 1'b0, 32'hBFC0_0480}    // R9
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drive for one cycle, results visible at the following negedge
   task automatic fire(input logic req, input logic [2:0] cls, input logic [4:0] code,
                       input logic ds, input logic [31:0] pc,
                       input logic er, input logic dr);
      @(negedge clk);
      exc_req_i = req; exc_class_i = cls; exc_code_i = code;
      in_dslot_i = ds; pc_i = pc; eret_i = er; deret_i = dr;
      @(negedge clk);
      exc_req_i = 0; eret_i = 0; deret_i = 0; in_dslot_i = 0;
   endtask

   initial begin
      #(8 * 100000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 redirect", redirect_o, 0);
      check("R13 epc", epc_o, 0);
      check("R13 errorepc", errorepc_o, 0);
      check("R13 depc", depc_o, 0);
      check("R13 cause", cause_o, 0);
      check("R13 dbg", dbg_mode_o, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         st_bev_i = TBL[i].bev; st_exl_i = TBL[i].exl;
         fire(1'b1, TBL[i].cls, TBL[i].code, 1'b0, 32'h100 + 32'(i) * 4, 1'b0, 1'b0);
         check("R1 R2 R3 table npc", npc_o, TBL[i].npc);
         check("R1 table redirect", redirect_o, 1);
         if (TBL[i].cls <= 3'd1)
            check("R6 table code", cause_o[6:2], TBL[i].code);
      end
      fire(1'b0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b0, 1'b1);   // leave debug mode
      st_bev_i = 0; st_exl_i = 0;

      // R4 first-level entry, no delay slot
      fire(1'b1, 3'd0, 5'd10, 1'b0, 32'h1000, 1'b0, 1'b0);
      check("R4 epc", epc_o, 32'h1000);
      check("R4 bd clear", cause_o[31], 0);
      check("R4 exl_set", exl_set_o, 1);
      @(negedge clk);
      check("R1 single pulse", redirect_o, 0);
      // R4 delay slot rewind
      fire(1'b1, 3'd0, 5'd12, 1'b1, 32'h2004, 1'b0, 1'b0);
      check("R4 epc rewind", epc_o, 32'h2000);
      check("R4 bd set", cause_o[31], 1);
      // R5 nested entry
      st_exl_i = 1;
      fire(1'b1, 3'd0, 5'd5, 1'b0, 32'h3000, 1'b0, 1'b0);
      check("R5 epc kept", epc_o, 32'h2000);
      check("R5 bd kept", cause_o[31], 1);
      check("R5 no exl_set", exl_set_o, 0);
      check("R6 code", cause_o, 32'h8000_0014);
      st_exl_i = 0;
      // R7 NMI in delay slot
      fire(1'b1, 3'd2, 5'd0, 1'b1, 32'h4008, 1'b0, 1'b0);
      check("R7 errorepc", errorepc_o, 32'h4004);
      check("R7 strobes", {erl_set_o, bev_set_o, nmi_set_o, sr_set_o}, 4'b1110);
      check("R7 npc", npc_o, 32'hBFC0_0000);
      // R8 soft reset
      fire(1'b1, 3'd3, 5'd0, 1'b0, 32'h5000, 1'b0, 1'b0);
      check("R8 errorepc", errorepc_o, 32'h5000);
      check("R8 strobes", {erl_set_o, bev_set_o, nmi_set_o, sr_set_o}, 4'b1101);
      // R9 debug in delay slot
      fire(1'b1, 3'd4, 5'd0, 1'b1, 32'h600C, 1'b0, 1'b0);
      check("R9 depc", depc_o, 32'h6008);
      check("R9 dbg", dbg_mode_o, 1);
      check("R9 epc kept", epc_o, 32'h2000);
      // R10 ERET error level
      st_erl_i = 1;
      fire(1'b0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      check("R10 npc errorepc", npc_o, 32'h5000);
      check("R10 strobes erl", {erl_clr_o, exl_clr_o, ll_clr_o}, 3'b101);
      st_erl_i = 0;
      // R10 ERET general level
      fire(1'b0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      check("R10 npc epc", npc_o, 32'h2000);
      check("R10 strobes exl", {erl_clr_o, exl_clr_o, ll_clr_o}, 3'b011);
      // R12 ERET beats DERET
      fire(1'b0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b1, 1'b1);
      check("R12 eret over deret", npc_o, 32'h2000);
      check("R12 dbg kept", dbg_mode_o, 1);
      // R11 DERET
      fire(1'b0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      check("R11 npc depc", npc_o, 32'h6008);
      check("R11 dbg cleared", dbg_mode_o, 0);
      check("R11 ll_clr", ll_clr_o, 1);
      // R12 exception beats ERET
      fire(1'b1, 3'd0, 5'd7, 1'b0, 32'h7000, 1'b1, 1'b0);
      check("R12 npc vector", npc_o, 32'h8000_0180);
      check("R12 no clears", {ll_clr_o, exl_clr_o, erl_clr_o}, 3'b000);
      check("R12 epc taken", epc_o, 32'h7000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule